// File: doc/BRIEF.md
# Masked Priority Interrupt Encoder

The block gathers thirteen level-sensitive interrupt lines, numbered 1 to 13, and gives the processor one request. It has the current interrupt level on three bits and an eight-bit vector. Each line is sampled into a pending register on every clock. A mask register can block any source. Every source has its own eight-bit control register and its own eight-bit vector register. Software programs them through a small synchronous register port. Timers are meant to be wired to lines 9 and 10, and serial ports to lines 12 and 13.

Selection runs over the sources that are pending and not masked. The low five bits of each control register form a priority code. The source with the largest nonzero code wins. Bits [4:2] of the winner's control register are driven as the processor level. The vector comes from the winner's vector register. When that register holds zero, the block uses the automatic vector 24 + level. Both outputs are registered.

Register map, word addressed: 0x00 pending (read only), 0x01 mask, 0x10+n control of source n, 0x20+n vector of source n. In the pending and mask words, bit n belongs to source n. Unmapped addresses read as zero and ignore writes.

Top module: `irq_prio_enc`

## Requirements
- R1: After reset the mask reads 0x3FFE, every control and vector register reads 0, the pending word reads 0, and the outputs are level 0 and vector 24.
- R2: Pending bit n (address 0x00) is 1 on the clock after line n is high, and 0 on the clock after it goes low.
- R3: A source whose mask bit is 1 is never selected. A source whose mask bit is 0 takes part in selection.
- R4: Bit 0 of the pending and mask words always reads 0. Writing 1 to mask bit 0 has no effect on selection or readback.
- R5: Among the active sources, the one with the strictly largest code in control bits [4:0] wins. Control bits [7:5] play no part in selection.
- R6: When the largest code is shared, the lowest-numbered source among those sharing it wins.
- R7: irqLevel equals bits [4:2] of the winning source's control register.
- R8: irqVector equals the winner's vector register when that register is nonzero. Otherwise it equals 24 + irqLevel.
- R9: A register write at clock edge k shows on irqLevel and irqVector at edge k+1, and not before.
- R10: The mask, control and vector registers read back the value last written (mask bits 13:1, control and vector bits 7:0).
- R11: With no active source, or only active sources whose code is 0, the outputs are level 0 and vector 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLine | input | 13 | Interrupt lines, bit n is source n (1..13) |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 6 | Register word address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data (combinational from busAddr) |
| irqLevel | output | 3 | Processor interrupt level |
| irqVector | output | 8 | Interrupt vector |

## Verification
Two actions can meet in the same clock: a line changing the pending set, and a register write that changes the mask or a priority code. The bench raises lines and then reprograms masks, codes and vector registers while those lines are held. It also checks the cycle right after a mask write to see that the outputs still show the old winner for exactly one edge. Judging is done by a model written in the bench from the requirements. That model predicts the winner, the level and the vector, including the equal-code and zero-code cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_PEND = 3'd1,
    RD_MASK = 3'd2,
    RD_CTRL = 3'd3,
    RD_VEC  = 3'd4
  } rdKind_t;

  typedef struct packed {
    logic             maskWe;
    logic             ctrlWe;
    logic             vecWe;
    rdKind_t          rdKind;
    logic [SEL_W-1:0] sel;
  } regStrobe_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam logic [1:0] PG_MISC = 2'd0;
  localparam logic [1:0] PG_CTRL = 2'd1;
  localparam logic [1:0] PG_VEC  = 2'd2;

  logic [1:0]       page;
  logic [SEL_W-1:0] idx;
  logic             idxOk;

  assign page  = busAddr[ADDR_W-1:ADDR_W-2];
  assign idx   = busAddr[SEL_W-1:0];
  assign idxOk = (idx != '0) && (int'(idx) <= NUM_SRC);

  always_comb begin
    strobe        = '0;
    strobe.rdKind = RD_NONE;
    strobe.sel    = idx;
    unique case (page)
      PG_MISC: begin
        if (idx == 4'd0) strobe.rdKind = RD_PEND;
        else if (idx == 4'd1) begin
          strobe.rdKind = RD_MASK;
          strobe.maskWe = busWe;
        end
      end
      PG_CTRL: if (idxOk) begin
        strobe.rdKind = RD_CTRL;
        strobe.ctrlWe = busWe;
      end
      PG_VEC: if (idxOk) begin
        strobe.rdKind = RD_VEC;
        strobe.vecWe  = busWe;
      end
      default: ;
    endcase
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.maskWe, strobe.ctrlWe, strobe.vecWe})) else $error("multi write"); // R10
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ctrlWe || strobe.vecWe) |-> (strobe.sel != '0 && int'(strobe.sel) <= NUM_SRC)) else $error("sel range"); // R10
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC:1]   srcLine,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [2:0]         irqLevel,
  output logic [7:0]         irqVector
);
  localparam int         CODE_W   = 5;
  localparam logic [7:0] AUTO_BASE = 8'd24;

  logic [NUM_SRC:1]      pendQ;
  logic [NUM_SRC:1]      maskQ;
  logic [NUM_SRC:1][7:0] ctrlQ;
  logic [NUM_SRC:1][7:0] vecRegQ;
  logic [NUM_SRC:1]      activeSet;

  logic [CODE_W-1:0] winCode;
  logic [SEL_W-1:0]  winIdx;
  logic              winValid;
  logic [2:0]        winLevel;
  logic [7:0]        winVecReg;
  logic [7:0]        nextVector;
  logic [2:0]        levelQ;
  logic [7:0]        vecQ;
  logic              unusedWrBits;

  assign unusedWrBits = ^{wrData[DATA_W-1:NUM_SRC+1], wrData[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      maskQ   <= '1;
      ctrlQ   <= '0;
      vecRegQ <= '0;
    end else begin
      pendQ <= srcLine;
      if (strobe.maskWe) maskQ <= wrData[NUM_SRC:1];
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (strobe.ctrlWe && int'(strobe.sel) == s) ctrlQ[s]   <= wrData[7:0];
        if (strobe.vecWe  && int'(strobe.sel) == s) vecRegQ[s] <= wrData[7:0];
      end
    end
  end

  assign activeSet = pendQ & ~maskQ;

  // Strict comparison in ascending order keeps the lowest index on ties.
  always_comb begin
    winCode  = '0;
    winIdx   = '0;
    winValid = 1'b0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (activeSet[s] && (ctrlQ[s][CODE_W-1:0] > winCode)) begin
        winCode  = ctrlQ[s][CODE_W-1:0];
        winIdx   = SEL_W'(s);
        winValid = 1'b1;
      end
    end
  end

  always_comb begin
    winLevel  = '0;
    winVecReg = '0;
    if (winValid) begin
      winLevel  = ctrlQ[winIdx][4:2];
      winVecReg = vecRegQ[winIdx];
    end
    nextVector = (winVecReg != 8'd0) ? winVecReg : AUTO_BASE + {5'd0, winLevel};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      vecQ   <= AUTO_BASE;
    end else begin
      levelQ <= winLevel;
      vecQ   <= nextVector;
    end
  end

  assign irqLevel  = levelQ;
  assign irqVector = vecQ;

  always_comb begin
    rdData = '0;
    unique case (strobe.rdKind)
      RD_PEND: rdData = DATA_W'({pendQ, 1'b0});
      RD_MASK: rdData = DATA_W'({maskQ, 1'b0});
      RD_CTRL: rdData = DATA_W'(ctrlQ[strobe.sel]);
      RD_VEC:  rdData = DATA_W'(vecRegQ[strobe.sel]);
      default: rdData = '0;
    endcase
  end

  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> !maskQ[winIdx]) else $error("masked winner"); // R3
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (activeSet == '0) |=> (irqLevel == 3'd0 && irqVector == AUTO_BASE)) else $error("idle out"); // R11
  AST_AUTO_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winVecReg == 8'd0) |=> (irqVector == AUTO_BASE + {5'd0, irqLevel})) else $error("autovec"); // R8
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pendQ) && $stable(maskQ) && $stable(ctrlQ) && $stable(vecRegQ)) |=>
      ($stable(irqLevel) && $stable(irqVector))) else $error("hold"); // R9
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC:1]  srcLine,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [2:0]        irqLevel,
  output logic [7:0]        irqVector
);
  regStrobe_t strobe;

  irq_prio_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .strobe(strobe)
  );

  irq_prio_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .srcLine(srcLine), .strobe(strobe),
    .wrData(busWrData), .rdData(busRdData),
    .irqLevel(irqLevel), .irqVector(irqVector)
  );
endmodule

// File: tb/irq_prio_enc_tb.sv
module irq_prio_enc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:1] srcLine = '0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [2:0]  irqLevel;
  logic [7:0]  irqVector;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_prio_enc dut_i (
    .clk(clk), .rstN(rstN), .srcLine(srcLine), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqLevel(irqLevel), .irqVector(irqVector)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWe = 1'b0; srcLine = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    @(negedge clk);
    busAddr = a;
    #1 v = int'(busRdData);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    int v;
    doReset();
    settle();
    chk("R1 level", irqLevel, 0);
    chk("R1 vector", irqVector, 24);
    rd(6'h01, v); chk("R1 mask", v, 16'h3FFE);
    rd(6'h11, v); chk("R1 ctrl1", v, 0);
    rd(6'h2D, v); chk("R1 vec13", v, 0);
    rd(6'h00, v); chk("R1 pending", v, 0);
  endtask

  task automatic tPending();
    int v;
    doReset();
    srcLine[3] = 1'b1; srcLine[9] = 1'b1;
    settle();
    rd(6'h00, v); chk("R2 pending set", v, (1 << 3) | (1 << 9));
    srcLine[3] = 1'b0;
    settle();
    rd(6'h00, v); chk("R2 pending clear", v, 1 << 9);
  endtask

  task automatic tMask();
    int v;
    doReset();
    wr(6'h19, 16'h001C);
    srcLine[9] = 1'b1;
    settle();
    chk("R3 masked level", irqLevel, 0);
    wr(6'h01, 16'h3FFE & ~(16'h1 << 9));
    settle();
    chk("R3 unmasked R7 level", irqLevel, 7);
    chk("R8 autovector", irqVector, 31);
    wr(6'h01, 16'h0001);
    settle();
    rd(6'h01, v); chk("R4 mask bit0", v, 0);
    rd(6'h00, v); chk("R4 pend bit0", v & 1, 0);
    chk("R4 still selects", irqLevel, 7);
  endtask

  task automatic tPriority();
    int v;
    doReset();
    wr(6'h15, 16'h000D);
    wr(6'h19, 16'h000A);
    wr(6'h01, 16'h0000);
    srcLine[5] = 1'b1; srcLine[9] = 1'b1;
    settle();
    chk("R5 larger code wins", irqLevel, 3);
    wr(6'h19, 16'h0010);
    settle();
    chk("R5 reprogram R7", irqLevel, 4);
    wr(6'h17, 16'h00E4);
    wr(6'h18, 16'h0005);
    wr(6'h27, 16'h0077);
    wr(6'h28, 16'h0088);
    wr(6'h01, 16'h0000);
    srcLine = '0; srcLine[7] = 1'b1; srcLine[8] = 1'b1;
    settle();
    chk("R5 upper bits ignored", irqVector, 8'h88);
    rd(6'h17, v); chk("R10 ctrl readback", v, 16'h00E4);
    rd(6'h27, v); chk("R10 vec readback", v, 16'h0077);
  endtask

  task automatic tTie();
    doReset();
    wr(6'h14, 16'h0008); wr(6'h24, 16'h0040);
    wr(6'h1B, 16'h0008); wr(6'h2B, 16'h0055);
    wr(6'h01, 16'h0000);
    srcLine[4] = 1'b1; srcLine[11] = 1'b1;
    settle();
    chk("R6 tie vector", irqVector, 8'h40);
    chk("R6 tie R7 level", irqLevel, 2);
    srcLine[4] = 1'b0;
    settle();
    chk("R8 vector register", irqVector, 8'h55);
  endtask

  task automatic tZeroCode();
    doReset();
    wr(6'h22, 16'h0099);
    wr(6'h01, 16'h0000);
    srcLine[2] = 1'b1;
    settle();
    chk("R11 zero code level", irqLevel, 0);
    chk("R11 zero code vector", irqVector, 24);
    wr(6'h12, 16'h0003);
    settle();
    chk("R8 level0 winner vector", irqVector, 8'h99);
  endtask

  task automatic tTiming();
    doReset();
    wr(6'h1C, 16'h0014);
    srcLine[12] = 1'b1;
    settle();
    @(negedge clk);
    busWe = 1'b1; busAddr = 6'h01; busWrData = 16'h0000;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
    chk("R9 old before edge k+1", irqLevel, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 new at edge k+1", irqLevel, 5);
    chk("R9 vector", irqVector, 29);
  endtask

  initial begin
    tReset();
    tPending();
    tMask();
    tPriority();
    tTie();
    tZeroCode();
    tTiming();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule